// File: doc/BRIEF.md
# Rotate, Shift and Single-Bit Operation Unit

This combinational unit carries out the second-byte rotate/shift group and the single-bit test/clear/set group of an 8-bit processor. It also covers the four short accumulator rotates and the two nibble rotates between the accumulator and a memory byte. The sequencer supplies the operand byte, the accumulator, the current flag byte and the second opcode byte. Two mode inputs pick the short accumulator forms or the nibble forms.

The unit returns the new operand byte with a write enable, and a new accumulator with its own write enable. It also returns the updated flag byte. Operand fetch, indexed addressing and memory cycles belong to the surrounding core. Every output settles in the same cycle as its inputs.

Top module: `rot_bit_unit`

## Requirements
- R1: With both mode inputs low and opcode[7:6]=00, opcode[5:3] selects the operation on the operand: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry, 4 shift left with 0 into bit 0, 5 arithmetic shift right keeping bit 7, 6 shift left with 1 into bit 0, 7 logical shift right with 0 into bit 7. The result is written (resultWe=1).
- R2: For an R1 operation the flags are set as follows:
  - S is result bit 7.
  - Z is 1 when the result is zero.
  - PV is 1 when the result has even parity.
  - H and N are 0.
  - C is the bit shifted out.
- R3: With both mode inputs low and opcode[7:6]=01, opcode[5:3] gives the index of the operand bit to test. Z becomes the inverse of that bit, H becomes 1 and N becomes 0. C, S and PV keep their values. resultWe is 0 and result equals the operand.
- R4: With both mode inputs low, opcode[7:6]=10 clears and 11 sets the operand bit indexed by opcode[5:3]. No other bit changes, the result is written, and flagsOut equals flagsIn.
- R5: With shortAcc high and nibbleRot low, opcode[4:3] selects the operation on the operand: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry. The result is written. Only C takes the bit shifted out, H and N are cleared, and S, Z and PV keep their values.
- R6: With nibbleRot high and opcode[3]=0, the byte moves are:
  - new memory byte = {accumulator low nibble, memory high nibble};
  - new accumulator = {accumulator high nibble, memory low nibble}.
  With opcode[3]=1, the byte moves are:
  - new memory byte = {memory low nibble, accumulator low nibble};
  - new accumulator = {accumulator high nibble, memory high nibble}.
  Both resultWe and accWe are 1.
- R7: In the nibble forms, S, Z and PV (even parity) are computed from the new accumulator, H and N are 0, and C keeps its value.
- R8: nibbleRot takes priority over shortAcc. accWe is 1 only in the nibble forms. Outside those forms accOut equals accIn.
- R9: The flag byte places S at bit 7, Z at bit 6, H at bit 4, PV at bit 2, N at bit 1 and C at bit 0. Bits 5 and 3 always pass through unchanged. The carry input of every operation is flagsIn[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 8 | Second opcode byte (or the short/nibble opcode) |
| shortAcc | input | 1 | Selects the short accumulator rotate forms |
| nibbleRot | input | 1 | Selects the nibble rotate forms |
| operand | input | 8 | Operand byte (register, memory or accumulator) |
| accIn | input | 8 | Current accumulator, used by the nibble forms |
| flagsIn | input | 8 | Current flag byte |
| result | output | 8 | New operand byte |
| resultWe | output | 1 | Write enable for result |
| accOut | output | 8 | New accumulator |
| accWe | output | 1 | Write enable for accOut |
| flagsOut | output | 8 | Updated flag byte |

## Verification
The unit is purely combinational, so any wrong decode or wrong carry path shows at the ports in the same cycle as the stimulus. A misdecoded operation class shows up as a write enable that is wrong for the opcode, or as flags that changed when they should have been kept. A wrong shifter fill bit shows up as a wrong bit 0 or bit 7 in the result. A wrong nibble route shows up as a wrong nibble in either the accumulator or the memory byte. A model computed from the requirements is compared against every port on each vector, using seeded random opcodes together with directed zero, all-ones and carry-boundary operands.

// File: rtl/rot_bit_pkg.sv
package rot_bit_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  localparam int FLAG_S  = 7;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_H  = 4;
  localparam int FLAG_PV = 2;
  localparam int FLAG_N  = 1;
  localparam int FLAG_C  = 0;

  typedef enum logic [2:0] {
    KIND_SHIFT = 3'd0,
    KIND_TEST  = 3'd1,
    KIND_CLR   = 3'd2,
    KIND_SET   = 3'd3,
    KIND_SHORT = 3'd4,
    KIND_NIBR  = 3'd5,
    KIND_NIBL  = 3'd6
  } kind_t;

  typedef struct packed {
    kind_t             kind;
    logic [2:0]        shiftSel;
    logic [IDX_W-1:0]  bitIdx;
    logic              resWe;
    logic              accWe;
  } ctrl_t;
endpackage

// File: rtl/rot_bit_ctrl.sv
module rot_bit_ctrl
  import rot_bit_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       shortAcc,
  input  logic       nibbleRot,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl.shiftSel = opcode[5:3];
    ctrl.bitIdx   = opcode[5:3];
    if (nibbleRot) begin
      ctrl.kind = opcode[3] ? KIND_NIBL : KIND_NIBR;
    end else if (shortAcc) begin
      ctrl.kind     = KIND_SHORT;
      ctrl.shiftSel = {1'b0, opcode[4:3]};
    end else begin
      case (opcode[7:6])
        2'b00:   ctrl.kind = KIND_SHIFT;
        2'b01:   ctrl.kind = KIND_TEST;
        2'b10:   ctrl.kind = KIND_CLR;
        default: ctrl.kind = KIND_SET;
      endcase
    end
    ctrl.resWe = (ctrl.kind != KIND_TEST);
    ctrl.accWe = (ctrl.kind == KIND_NIBR) || (ctrl.kind == KIND_NIBL);
  end

  always_comb begin
    assert_acc_we_nibble_only_R8: assert (ctrl.accWe == nibbleRot)
      else $error("accWe does not follow nibble mode");
  end
endmodule

// File: rtl/rot_bit_dp.sv
module rot_bit_dp
  import rot_bit_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  ctrl_t        ctrl,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] accIn,
  input  logic [7:0]   flagsIn,
  output logic [W-1:0] result,
  output logic         resultWe,
  output logic [W-1:0] accOut,
  output logic         accWe,
  output logic [7:0]   flagsOut
);
  localparam int NIB = W / 2;

  logic         carryIn;
  logic [W-1:0] shifted;
  logic         shiftOut;
  logic [W-1:0] bitMask;
  logic [W-1:0] nibMem;
  logic [W-1:0] nibAcc;
  logic [NIB-1:0] accLo, accHi, memLo, memHi;

  assign carryIn = flagsIn[FLAG_C];

  // Shifter: one of eight fill/out patterns
  always_comb begin
    shifted  = operand;
    shiftOut = 1'b0;
    case (ctrl.shiftSel)
      3'd0: begin shifted = {operand[W-2:0], operand[W-1]}; shiftOut = operand[W-1]; end
      3'd1: begin shifted = {operand[0], operand[W-1:1]};   shiftOut = operand[0];   end
      3'd2: begin shifted = {operand[W-2:0], carryIn};      shiftOut = operand[W-1]; end
      3'd3: begin shifted = {carryIn, operand[W-1:1]};      shiftOut = operand[0];   end
      3'd4: begin shifted = {operand[W-2:0], 1'b0};         shiftOut = operand[W-1]; end
      3'd5: begin shifted = {operand[W-1], operand[W-1:1]}; shiftOut = operand[0];   end
      3'd6: begin shifted = {operand[W-2:0], 1'b1};         shiftOut = operand[W-1]; end
      default: begin shifted = {1'b0, operand[W-1:1]};      shiftOut = operand[0];   end
    endcase
  end

  // One-hot mask of the addressed bit
  for (genvar gi = 0; gi < W; gi++) begin : g_mask
    assign bitMask[gi] = (ctrl.bitIdx == gi[IDX_W-1:0]);
  end

  // Nibble routing
  assign accLo = accIn[NIB-1:0];
  assign accHi = accIn[W-1:NIB];
  assign memLo = operand[NIB-1:0];
  assign memHi = operand[W-1:NIB];

  always_comb begin
    if (ctrl.kind == KIND_NIBL) begin
      nibMem = {memLo, accLo};
      nibAcc = {accHi, memHi};
    end else begin
      nibMem = {accLo, memHi};
      nibAcc = {accHi, memLo};
    end
  end

  // Result and flag assembly
  always_comb begin
    result   = operand;
    accOut   = accIn;
    flagsOut = flagsIn;
    case (ctrl.kind)
      KIND_SHIFT: begin
        result = shifted;
        flagsOut[FLAG_S]  = shifted[W-1];
        flagsOut[FLAG_Z]  = (shifted == '0);
        flagsOut[FLAG_PV] = ~^shifted;
        flagsOut[FLAG_H]  = 1'b0;
        flagsOut[FLAG_N]  = 1'b0;
        flagsOut[FLAG_C]  = shiftOut;
      end
      KIND_SHORT: begin
        result = shifted;
        flagsOut[FLAG_H] = 1'b0;
        flagsOut[FLAG_N] = 1'b0;
        flagsOut[FLAG_C] = shiftOut;
      end
      KIND_TEST: begin
        flagsOut[FLAG_Z] = ~|(operand & bitMask);
        flagsOut[FLAG_H] = 1'b1;
        flagsOut[FLAG_N] = 1'b0;
      end
      KIND_CLR: result = operand & ~bitMask;
      KIND_SET: result = operand | bitMask;
      KIND_NIBR, KIND_NIBL: begin
        result = nibMem;
        accOut = nibAcc;
        flagsOut[FLAG_S]  = nibAcc[W-1];
        flagsOut[FLAG_Z]  = (nibAcc == '0);
        flagsOut[FLAG_PV] = ~^nibAcc;
        flagsOut[FLAG_H]  = 1'b0;
        flagsOut[FLAG_N]  = 1'b0;
      end
      default: ;
    endcase
  end

  assign resultWe = ctrl.resWe;
  assign accWe    = ctrl.accWe;

  always_comb begin
    if (ctrl.kind == KIND_TEST) begin
      assert_test_no_write_R3: assert (!resultWe && result == operand)
        else $error("bit test wrote a result");
    end
    if (ctrl.kind == KIND_CLR || ctrl.kind == KIND_SET) begin
      assert_bitop_one_bit_R4: assert (flagsOut == flagsIn && $countones(result ^ operand) <= 1)
        else $error("bit set/clear touched more than one bit or a flag");
    end
    if (ctrl.kind == KIND_SHORT) begin
      assert_short_keeps_szp_R5: assert (flagsOut[FLAG_S] == flagsIn[FLAG_S] &&
                                         flagsOut[FLAG_Z] == flagsIn[FLAG_Z] &&
                                         flagsOut[FLAG_PV] == flagsIn[FLAG_PV])
        else $error("short rotate changed S/Z/PV");
    end
    if (accWe) begin
      assert_nibble_conserve_R6: assert ($countones({accOut, result}) == $countones({accIn, operand})
                                         && accOut[W-1:NIB] == accIn[W-1:NIB])
        else $error("nibble rotate lost bits");
      assert_nibble_carry_R7: assert (flagsOut[FLAG_C] == flagsIn[FLAG_C])
        else $error("nibble rotate changed carry");
    end
    assert_spare_flags_R9: assert (flagsOut[5] == flagsIn[5] && flagsOut[3] == flagsIn[3])
      else $error("spare flag bits changed");
  end
endmodule

// File: rtl/rot_bit_unit.sv
module rot_bit_unit
  import rot_bit_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       shortAcc,
  input  logic       nibbleRot,
  input  logic [7:0] operand,
  input  logic [7:0] accIn,
  input  logic [7:0] flagsIn,
  output logic [7:0] result,
  output logic       resultWe,
  output logic [7:0] accOut,
  output logic       accWe,
  output logic [7:0] flagsOut
);
  ctrl_t ctrl;

  rot_bit_ctrl u_ctrl (
    .opcode    (opcode),
    .shortAcc  (shortAcc),
    .nibbleRot (nibbleRot),
    .ctrl      (ctrl)
  );

  rot_bit_dp #(.W(DATA_W)) u_dp (
    .ctrl     (ctrl),
    .operand  (operand),
    .accIn    (accIn),
    .flagsIn  (flagsIn),
    .result   (result),
    .resultWe (resultWe),
    .accOut   (accOut),
    .accWe    (accWe),
    .flagsOut (flagsOut)
  );
endmodule

// File: tb/test_rot_bit_unit.sv
module test_rot_bit_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] opcode = 8'h00, operand = 8'h00, accIn = 8'h00, flagsIn = 8'h00;
  logic shortAcc = 1'b0, nibbleRot = 1'b0;
  logic [7:0] result, accOut, flagsOut;
  logic resultWe, accWe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  rot_bit_unit i_rot_bit_unit (
    .opcode(opcode), .shortAcc(shortAcc), .nibbleRot(nibbleRot),
    .operand(operand), .accIn(accIn), .flagsIn(flagsIn),
    .result(result), .resultWe(resultWe), .accOut(accOut),
    .accWe(accWe), .flagsOut(flagsOut)
  );

  // Model packs {result, resultWe, accOut, accWe, flags} = 26 bits
  function automatic logic [25:0] model(input logic [7:0] op, input logic sh, input logic nb,
                                        input logic [7:0] d, input logic [7:0] a, input logic [7:0] f);
    logic [7:0] r = d, ao = a, fo = f;
    logic rw = 1'b1, aw = 1'b0, c = f[0], co = 1'b0;
    int sel;
    if (nb) begin
      aw = 1'b1;
      if (!op[3]) begin r = {a[3:0], d[7:4]}; ao = {a[7:4], d[3:0]}; end
      else        begin r = {d[3:0], a[3:0]}; ao = {a[7:4], d[7:4]}; end
      fo[7] = ao[7]; fo[6] = (ao == 0); fo[2] = ~^ao; fo[4] = 0; fo[1] = 0;
    end else if (sh || op[7:6] == 2'b00) begin
      sel = sh ? int'(op[4:3]) : int'(op[5:3]);
      case (sel)
        0: begin r = (d << 1) | {7'd0, d[7]}; co = d[7]; end
        1: begin r = (d >> 1) | {d[0], 7'd0}; co = d[0]; end
        2: begin r = (d << 1) | {7'd0, c};    co = d[7]; end
        3: begin r = (d >> 1) | {c, 7'd0};    co = d[0]; end
        4: begin r = d << 1;                  co = d[7]; end
        5: begin r = (d >> 1) | (d & 8'h80);  co = d[0]; end
        6: begin r = (d << 1) | 8'h01;        co = d[7]; end
        default: begin r = d >> 1;            co = d[0]; end
      endcase
      fo[0] = co; fo[4] = 0; fo[1] = 0;
      if (!sh) begin fo[7] = r[7]; fo[6] = (r == 0); fo[2] = ~^r; end
    end else if (op[7:6] == 2'b01) begin
      rw = 1'b0;
      fo[6] = ~d[op[5:3]]; fo[4] = 1; fo[1] = 0;
    end else if (op[7:6] == 2'b10) begin
      r[op[5:3]] = 1'b0;
    end else begin
      r[op[5:3]] = 1'b1;
    end
    return {r, rw, ao, aw, fo};
  endfunction

  function automatic string reqOf(input logic [7:0] op, input logic sh, input logic nb);
    if (nb) return "R6/R7";
    if (sh) return "R5";
    case (op[7:6])
      2'b00: return "R1/R2";
      2'b01: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic apply(input logic [7:0] op, input logic sh, input logic nb,
                       input logic [7:0] d, input logic [7:0] a, input logic [7:0] f, input string req);
    logic [25:0] exp, act;
    @(posedge clk);
    opcode = op; shortAcc = sh; nibbleRot = nb; operand = d; accIn = a; flagsIn = f;
    @(negedge clk);
    exp = model(op, sh, nb, d, a, f);
    act = {result, resultWe, accOut, accWe, flagsOut};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s op=%h sh=%0b nb=%0b d=%h a=%h f=%h actual=%h expected=%h",
               req, op, sh, nb, d, a, f, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // Reset-state inputs all zero: shift-group op 0 on zero operand (R1, R2)
    apply(8'h00, 0, 0, 8'h00, 8'h00, 8'h00, "R2 reset");
    // R1: each shift kind on a pattern with both edge bits set, carry in 1 and 0
    for (int k = 0; k < 8; k++) begin
      apply(8'(k << 3), 0, 0, 8'h81, 8'h00, 8'h01, "R1");
      apply(8'(k << 3), 0, 0, 8'h7E, 8'h00, 8'h00, "R1");
    end
    // R2: zero result with carry out
    apply(8'h38, 0, 0, 8'h01, 8'h00, 8'h00, "R2 zero");
    apply(8'h20, 0, 0, 8'h80, 8'h00, 8'hFF, "R2 zero");
    // R3: test bit 7 and bit 0, flags with C/S/PV set kept
    apply(8'h78, 0, 0, 8'h80, 8'h00, 8'hA5, "R3");
    apply(8'h40, 0, 0, 8'hFE, 8'h00, 8'h85, "R3");
    // R4: clear and set boundary bits
    apply(8'hBE, 0, 0, 8'hFF, 8'h00, 8'h55, "R4");
    apply(8'hC0, 0, 0, 8'h00, 8'h00, 8'hAA, "R4");
    apply(8'hF8, 0, 0, 8'h80, 8'h00, 8'h00, "R4");
    // R5: four short rotates, S/Z/PV preset to be kept
    for (int k = 0; k < 4; k++) begin
      apply(8'(8'h07 | (k << 3)), 1, 0, 8'h80, 8'h00, 8'hC4, "R5");
      apply(8'(8'h07 | (k << 3)), 1, 0, 8'h01, 8'h00, 8'h01, "R5");
    end
    // R6, R7: both nibble directions, zero accumulator result
    apply(8'h67, 0, 1, 8'h12, 8'h34, 8'h01, "R6");
    apply(8'h6F, 0, 1, 8'h12, 8'h34, 8'h00, "R6");
    apply(8'h67, 0, 1, 8'hF0, 8'h00, 8'h00, "R7 zero");
    // R8: nibble beats short form
    apply(8'h6F, 1, 1, 8'hAB, 8'hCD, 8'h28, "R8");
    // R9: spare bits pass in every class
    apply(8'h10, 0, 0, 8'h55, 8'h00, 8'h28, "R9");
    apply(8'h50, 0, 0, 8'h55, 8'h00, 8'h28, "R9");
    // Seeded random mix
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 600; n++) begin
      logic [7:0] op, d, a, f;
      logic sh, nb;
      op = 8'($urandom); d = 8'($urandom); a = 8'($urandom); f = 8'($urandom);
      nb = ($urandom % 6) == 0;
      sh = ($urandom % 5) == 0;
      if (sh && !nb) op = {3'b000, op[4:3], 3'b111};
      apply(op, sh, nb, d, a, f, reqOf(op, sh, nb));
    end
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule